// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word-select clock and one data line. It shifts in one left and one right sample per frame. It turns each sample into a 24-bit two's complement word and hands the pair to the system clock domain with a one-cycle valid strobe. A 3-bit format code picks the framing. The choices are right-justified words of 24, 20, 18 or 16 bits, I2S, or left-justified.

The deserializer runs on the bit clock itself. A finished frame crosses into the system clock domain through a toggle handshake, and both channel words cross together. The receiver compares the length of each frame, counted in bit clocks, with the length of the frame before it. It also watches for frames that stop arriving. Either disturbance mutes the output while the link settles. Reserved format codes and I2S at 32 bit clocks per frame count as unusable frames.

Top module: `audio_serial_rx`

## Requirements
- R1: With format code 101 (left-justified), data sampled on rising bit clock edges is captured MSB first. The MSB is the first bit after the word-select change, and the left channel is the slot with word select high. Only the first 24 bits of a slot are kept. A shorter word is zero-filled at the LSB end.
- R2: With format code 100 (I2S), the left channel is the slot with word select low. The first bit of each slot is ignored, and the MSB is the second bit. Up to 24 bits are kept, zero-filled at the LSB end.
- R3: Format codes 000, 001, 010 and 011 select right-justified words of 24, 20, 18 and 16 bits. The LSB is the last bit before word select changes level. Earlier bits in the slot are ignored, and the word is sign-extended to 24 bits.
- R4: A frame is a left slot followed by a right slot. It is delivered when word select next enters the left level. Left and right words appear together on the outputs with `outValid` high for exactly one system clock. The outputs do not change while `outValid` is low.
- R5: A frame whose bit-clock count differs from the previous frame's count is unusable. The first frame after reset is always unusable.
- R6: An unusable frame is delivered as zeros. A usable frame is delivered with its data only when it and the three frames before it were all usable (MUTE_FRAMES = 3). Otherwise it is delivered as zeros.
- R7: If no frame reaches the system side for TIMEOUT_CYCLES system clocks, the run of usable frames restarts. The next three delivered frames are zeros, and the fourth carries data.
- R8: Format codes 110 and 111 are reserved, and every frame received under them is delivered as zeros.
- R9: In I2S mode, a frame of 32 bit clocks is unusable and is delivered as zeros.
- R10: While reset is asserted, and after it until the first frame, `outValid` is low and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; outputs are registered on it |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| bitClk | input | 1 | Serial bit clock; data sampled on its rising edge |
| wordSel | input | 1 | Word-select clock at the sample rate |
| serData | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 3 | Framing code, held static while out of reset |
| leftOut | output | 24 | Left sample, sign-extended or zero-filled |
| rightOut | output | 24 | Right sample, sign-extended or zero-filled |
| outValid | output | 1 | One-cycle strobe marking a delivered frame |

## Verification
The assertions check the following on every clock:
- a frame flagged unusable appears as zeros on the next system clock;
- a restarted usable run forces zeros;
- the idle timeout clears the run;
- the valid strobe lasts one cycle;
- under reserved codes the frame is flagged unusable;
- right-justified 16-bit words are sign-extended, and short left-justified slots are zero-filled.

Only the bench's scenarios can show that each framing places its MSB and LSB correctly in the bit stream. They also show that the ignored bits really have no effect. Finally, they show that the mute count, rate changes and a stopped clock yield exactly the right sequence of zero and data frames.

// File: rtl/asrx_pkg.sv
`timescale 1ns/1ps
package asrx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int POS_W = 6;
  localparam int LEN_W = 8;
  localparam int MIN_FRAME_BITS = 32;

  localparam logic [2:0] FMT_RJ24 = 3'b000;
  localparam logic [2:0] FMT_RJ20 = 3'b001;
  localparam logic [2:0] FMT_RJ18 = 3'b010;
  localparam logic [2:0] FMT_RJ16 = 3'b011;
  localparam logic [2:0] FMT_I2S  = 3'b100;
  localparam logic [2:0] FMT_LJ   = 3'b101;

  // strobes from the bit-clock control to the datapath
  typedef struct packed {
    logic             slotEdge;   // first bit of a new slot
    logic             storeLeft;  // a left slot just finished
    logic             emit;       // a right slot just finished: frame done
    logic             frameBad;   // finished frame is unusable
    logic [POS_W-1:0] pos;        // bit position within current slot
  } rx_strobe_t;

  function automatic logic fmtIsRj(input logic [2:0] fmt);
    return fmt[2] == 1'b0;
  endfunction

  function automatic logic fmtReserved(input logic [2:0] fmt);
    return fmt[2:1] == 2'b11;
  endfunction

  function automatic int rjWidth(input logic [2:0] fmt);
    case (fmt)
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      FMT_RJ16: return 16;
      default:  return 24;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] signExt(input logic [SAMPLE_W-1:0] v, input int n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++)
      r[i] = (i < n) ? v[i] : v[IDX_W'(n - 1)];
    return r;
  endfunction
endpackage

// File: rtl/asrx_ctrl.sv
`timescale 1ns/1ps
module asrx_ctrl
  import asrx_pkg::*;
(
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       wordSel,
  input  logic [2:0] fmt,
  output rx_strobe_t strobes
);
  logic             seen, primed, prevWs;
  logic [LEN_W-1:0] frameCnt, prevLen;
  logic [POS_W-1:0] pos;
  logic             leftLevel, wsEdge, finLeft;

  always_comb begin
    leftLevel         = (fmt != FMT_I2S);
    wsEdge            = seen && (wordSel != prevWs);
    finLeft           = (prevWs == leftLevel);
    strobes.slotEdge  = wsEdge;
    strobes.storeLeft = wsEdge && primed && finLeft;
    strobes.emit      = wsEdge && primed && !finLeft;
    strobes.frameBad  = (frameCnt != prevLen) || fmtReserved(fmt) ||
                        ((fmt == FMT_I2S) && (frameCnt == LEN_W'(MIN_FRAME_BITS)));
    strobes.pos       = pos;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      seen     <= 1'b0;
      primed   <= 1'b0;
      prevWs   <= 1'b0;
      frameCnt <= '0;
      prevLen  <= '0;
      pos      <= '0;
    end else begin
      seen   <= 1'b1;
      prevWs <= wordSel;
      if (wsEdge) primed <= 1'b1;
      if (strobes.emit || (wsEdge && !primed)) frameCnt <= LEN_W'(1);
      else if (frameCnt != '1)                 frameCnt <= frameCnt + 1'b1;
      if (strobes.emit) prevLen <= frameCnt;
      if (wsEdge)          pos <= POS_W'(1);
      else if (pos != '1)  pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/asrx_deser.sv
`timescale 1ns/1ps
module asrx_deser
  import asrx_pkg::*;
(
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                serData,
  input  logic [2:0]          fmt,
  input  rx_strobe_t          strobes,
  output logic [SAMPLE_W-1:0] leftHold,
  output logic [SAMPLE_W-1:0] rightHold,
  output logic                badHold,
  output logic                frameTgl
);
  logic [SAMPLE_W-1:0] shiftReg, slotWord, leftWord, finWord;
  logic                capEn;
  int                  capIdx;

  always_comb begin
    if (fmtReserved(fmt))  finWord = '0;
    else if (fmtIsRj(fmt)) finWord = signExt(shiftReg, rjWidth(fmt));
    else                   finWord = slotWord;
  end

  always_comb begin
    capEn  = 1'b0;
    capIdx = 0;
    if (fmt == FMT_LJ && int'(strobes.pos) < SAMPLE_W) begin
      capEn  = 1'b1;
      capIdx = SAMPLE_W - 1 - int'(strobes.pos);
    end else if (fmt == FMT_I2S && strobes.pos != '0 && int'(strobes.pos) <= SAMPLE_W) begin
      capEn  = 1'b1;
      capIdx = SAMPLE_W - int'(strobes.pos);
    end
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      slotWord  <= '0;
      leftWord  <= '0;
      leftHold  <= '0;
      rightHold <= '0;
      badHold   <= 1'b0;
      frameTgl  <= 1'b0;
    end else begin
      shiftReg <= {shiftReg[SAMPLE_W-2:0], serData};
      if (strobes.slotEdge)
        slotWord <= (fmt == FMT_LJ) ? {serData, {(SAMPLE_W-1){1'b0}}} : '0;
      else
        for (int i = 0; i < SAMPLE_W; i++)
          if (capEn && capIdx == i) slotWord[i] <= serData;
      if (strobes.storeLeft) leftWord <= finWord;
      if (strobes.emit) begin
        leftHold  <= leftWord;
        rightHold <= finWord;
        badHold   <= strobes.frameBad;
        frameTgl  <= ~frameTgl;
      end
    end
  end

  // R3
  rj_sext_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobes.emit && fmt == FMT_RJ16) |=> (rightHold[23:16] == {8{rightHold[15]}}));
  // R8
  rsv_bad_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobes.emit && fmtReserved(fmt)) |=> badHold);
  // R1
  lj_short_pad_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobes.emit && fmt == FMT_LJ && strobes.pos == POS_W'(16)) |=> (rightHold[7:0] == '0));
endmodule

// File: rtl/asrx_xfer.sv
`timescale 1ns/1ps
module asrx_xfer
  import asrx_pkg::*;
#(
  parameter int MUTE_FRAMES    = 3,
  parameter int TIMEOUT_CYCLES = 2048
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                frameTgl,
  input  logic [SAMPLE_W-1:0] leftHold,
  input  logic [SAMPLE_W-1:0] rightHold,
  input  logic                badHold,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                outValid
);
  localparam int RUN_MAX = MUTE_FRAMES + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int IDLE_W  = $clog2(TIMEOUT_CYCLES + 1);

  logic [2:0]        syncTgl;
  logic              frameNew, passData;
  logic [RUN_W-1:0]  runCnt, runNext;
  logic [IDLE_W-1:0] idleCnt;

  always_comb begin
    frameNew = syncTgl[2] ^ syncTgl[1];
    if (badHold)                         runNext = '0;
    else if (runCnt == RUN_W'(RUN_MAX))  runNext = runCnt;
    else                                 runNext = runCnt + 1'b1;
    passData = (runNext == RUN_W'(RUN_MAX));
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      syncTgl  <= '0;
      runCnt   <= '0;
      idleCnt  <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      outValid <= 1'b0;
    end else begin
      syncTgl  <= {syncTgl[1:0], frameTgl};
      outValid <= frameNew;
      if (frameNew) begin
        runCnt   <= runNext;
        idleCnt  <= '0;
        leftOut  <= passData ? leftHold  : '0;
        rightOut <= passData ? rightHold : '0;
      end else begin
        if (idleCnt != IDLE_W'(TIMEOUT_CYCLES)) idleCnt <= idleCnt + 1'b1;
        else                                    runCnt  <= '0;
      end
    end
  end

  // R6
  bad_zero_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (frameNew && badHold) |=> (outValid && leftOut == '0 && rightOut == '0));
  // R6
  run_mute_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (frameNew && runCnt == '0) |=> (leftOut == '0 && rightOut == '0));
  // R7
  idle_clear_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (idleCnt == IDLE_W'(TIMEOUT_CYCLES) && !frameNew) |=> (runCnt == '0));
  // R4
  valid_pulse_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    outValid |=> !outValid);
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx #(
  parameter int MUTE_FRAMES    = 3,
  parameter int TIMEOUT_CYCLES = 2048
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        bitClk,
  input  logic        wordSel,
  input  logic        serData,
  input  logic [2:0]  fmtSel,
  output logic [23:0] leftOut,
  output logic [23:0] rightOut,
  output logic        outValid
);
  import asrx_pkg::*;

  rx_strobe_t          strobes;
  logic [SAMPLE_W-1:0] leftHold, rightHold;
  logic                badHold, frameTgl;

  asrx_ctrl uCtrl (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .wordSel (wordSel),
    .fmt     (fmtSel),
    .strobes (strobes)
  );

  asrx_deser uDeser (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .serData   (serData),
    .fmt       (fmtSel),
    .strobes   (strobes),
    .leftHold  (leftHold),
    .rightHold (rightHold),
    .badHold   (badHold),
    .frameTgl  (frameTgl)
  );

  asrx_xfer #(
    .MUTE_FRAMES    (MUTE_FRAMES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) uXfer (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .frameTgl  (frameTgl),
    .leftHold  (leftHold),
    .rightHold (rightHold),
    .badHold   (badHold),
    .leftOut   (leftOut),
    .rightOut  (rightOut),
    .outValid  (outValid)
  );
endmodule

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordSel = 1'b0;
  logic        serData = 1'b0;
  logic [2:0]  fmtSel = 3'b101;
  logic [23:0] leftOut, rightOut;
  logic        outValid;

  audio_serial_rx #(.MUTE_FRAMES(3), .TIMEOUT_CYCLES(2048)) u0 (
    .sysClk(sysClk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel),
    .serData(serData), .fmtSel(fmtSel), .leftOut(leftOut),
    .rightOut(rightOut), .outValid(outValid));

  always #2.5 sysClk = ~sysClk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [23:0] expL[$], expR[$];
  string       expTag[$];
  logic [23:0] lastL = '0, lastR = '0, el, er;
  string       et;

  // behavioural frame-level model state
  int          prevBits = 0, run = 0;
  bit          pendValid = 1'b0, pendBad = 1'b0;
  logic [23:0] pendL, pendR;
  string       pendBadTag = "", muteTag = "R6", scenTag = "R1";

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #950000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: run hung (actual running, expected finished)");
      summary();
    end
  end

  // compared on every system clock, away from the active edge
  always @(negedge sysClk) begin
    if (rstN) begin
      if (outValid) begin
        checks++;
        if (expL.size() == 0) begin
          errors++;
          $display("FAIL R4 unexpected frame actual %h/%h expected none", leftOut, rightOut);
        end else begin
          el = expL.pop_front(); er = expR.pop_front(); et = expTag.pop_front();
          if (leftOut !== el || rightOut !== er) begin
            errors++;
            $display("FAIL %s actual %h/%h expected %h/%h", et, leftOut, rightOut, el, er);
          end
        end
        lastL = leftOut; lastR = rightOut;
      end else if (leftOut !== lastL || rightOut !== lastR) begin
        checks++; errors++;
        $display("FAIL R4 outputs moved without strobe actual %h/%h expected %h/%h",
                 leftOut, rightOut, lastL, lastR);
        lastL = leftOut; lastR = rightOut;
      end
    end
  end

  function automatic logic leftLvl();
    return fmtSel != 3'b100;
  endfunction

  function automatic logic slotBit(input logic [23:0] w, input int n, input int slot, input int p);
    case (fmtSel)
      3'b101:  return (p < n) ? w[n-1-p] : ((p >= 24) ? 1'b1 : 1'b0);
      3'b100:  return (p == 0) ? 1'b1 : ((p <= n) ? w[n-p] : ((p > 24) ? 1'b1 : 1'b0));
      default: return (p >= slot - n) ? w[slot-1-p] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] expWord(input logic [23:0] wIn, input int n, input int slot);
    logic [23:0] w, v;
    int c;
    w = wIn;
    for (int i = n; i < 24; i++) w[i] = 1'b0;
    case (fmtSel)
      3'b101:  begin v = w << (24 - n); c = (slot < 24) ? slot : 24; end
      3'b100:  begin v = w << (24 - n); c = (slot - 1 < 24) ? slot - 1 : 24; end
      default: begin v = w; for (int i = n; i < 24; i++) v[i] = w[n-1]; c = 24; end
    endcase
    for (int i = 0; i < 24 - c; i++) v[i] = 1'b0;
    return v;
  endfunction

  task automatic sendBit(input logic ws, input logic d);
    wordSel = ws; serData = d;
    #20 bitClk = 1'b1;
    #20 bitClk = 1'b0;
  endtask

  task automatic pushPending();
    if (pendValid) begin
      if (pendBad) begin
        run = 0; muteTag = pendBadTag;
        expL.push_back('0); expR.push_back('0); expTag.push_back(pendBadTag);
      end else begin
        if (run < 4) run++;
        if (run >= 4) begin
          expL.push_back(pendL); expR.push_back(pendR); expTag.push_back(scenTag);
        end else begin
          expL.push_back('0); expR.push_back('0); expTag.push_back(muteTag);
        end
      end
      pendValid = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [23:0] lw, input logic [23:0] rw, input int n, input int slot);
    int bits;
    pushPending();
    for (int p = 0; p < slot; p++) sendBit(leftLvl(), slotBit(lw, n, slot, p));
    for (int p = 0; p < slot; p++) sendBit(!leftLvl(), slotBit(rw, n, slot, p));
    pendL = expWord(lw, n, slot);
    pendR = expWord(rw, n, slot);
    bits = 2 * slot;
    if (fmtSel[2:1] == 2'b11)                 pendBadTag = "R8";
    else if (fmtSel == 3'b100 && bits == 32)  pendBadTag = "R9";
    else if (bits != prevBits)                pendBadTag = "R5";
    else                                      pendBadTag = "";
    pendBad = (pendBadTag != "");
    prevBits = bits;
    pendValid = 1'b1;
  endtask

  task automatic leadIn(input int slot);
    for (int p = 0; p < slot; p++) sendBit(!leftLvl(), 1'b0);
  endtask

  task automatic finishStream(input int n, input int slot);
    sendFrame(24'h0, 24'h0, n, slot);
    #300;
    checks++;
    if (expL.size() != 0) begin
      errors++;
      $display("FAIL R4 frames not delivered actual %0d pending expected 0", expL.size());
    end
  endtask

  task automatic resetDut(input logic [2:0] f);
    @(negedge sysClk);
    rstN = 1'b0;
    lastL = '0; lastR = '0;
    expL.delete(); expR.delete(); expTag.delete();
    pendValid = 1'b0; prevBits = 0; run = 0; muteTag = "R6";
    fmtSel = f;
    wordSel = !leftLvl();
    serData = 1'b0;
    repeat (5) @(negedge sysClk);
    checks++;
    if (outValid !== 1'b0 || leftOut !== '0 || rightOut !== '0) begin
      errors++;
      $display("FAIL R10 reset state actual %b %h/%h expected 0 000000/000000",
               outValid, leftOut, rightOut);
    end
    rstN = 1'b1;
    repeat (3) @(negedge sysClk);
    checks++;
    if (outValid !== 1'b0 || leftOut !== '0 || rightOut !== '0) begin
      errors++;
      $display("FAIL R10 after reset actual %b %h/%h expected 0 000000/000000",
               outValid, leftOut, rightOut);
    end
  endtask

  function automatic logic [23:0] patL(input int k);
    return 24'h8A3C97 + 24'(k) * 24'h1F2E3D;
  endfunction
  function automatic logic [23:0] patR(input int k);
    return ~(24'h35D1E6 + 24'(k) * 24'h0B5A73);
  endfunction

  task automatic runStream(input logic [2:0] f, input int n, input int slot, input int frames, input string tag);
    resetDut(f);
    scenTag = tag;
    leadIn(slot);
    for (int k = 0; k < frames; k++) sendFrame(patL(k), patR(k), n, slot);
    finishStream(n, slot);
  endtask

  initial begin
    // R1 left-justified
    runStream(3'b101, 24, 32, 7, "R1");
    runStream(3'b101, 16, 24, 7, "R1");
    runStream(3'b101, 24, 16, 7, "R1");
    // R2 I2S
    runStream(3'b100, 24, 32, 7, "R2");
    runStream(3'b100, 20, 24, 7, "R2");
    // R9 I2S at 32 bit clocks per frame
    runStream(3'b100, 16, 16, 6, "R9");
    // R3 right-justified widths
    runStream(3'b000, 24, 32, 7, "R3");
    runStream(3'b001, 20, 24, 7, "R3");
    runStream(3'b010, 18, 32, 7, "R3");
    runStream(3'b011, 16, 16, 7, "R3");
    // R8 reserved codes
    runStream(3'b110, 24, 32, 5, "R8");
    runStream(3'b111, 16, 16, 5, "R8");
    // R5 rate change mid-stream
    resetDut(3'b101);
    scenTag = "R5";
    leadIn(32);
    for (int k = 0; k < 6; k++) sendFrame(patL(k), patR(k), 24, 32);
    for (int k = 6; k < 12; k++) sendFrame(patL(k), patR(k), 24, 24);
    finishStream(24, 24);
    // R7 stopped clocks
    resetDut(3'b011);
    scenTag = "R7";
    leadIn(32);
    for (int k = 0; k < 6; k++) sendFrame(patL(k), patR(k), 16, 32);
    #15000;
    run = 0; muteTag = "R7";
    for (int k = 6; k < 12; k++) sendFrame(patL(k), patR(k), 16, 32);
    finishStream(16, 32);
    done = 1'b1;
    summary();
  end
endmodule